// File: doc/BRIEF.md
# Quarter-Word Multiply-Accumulate Unit

This unit is the wide multiply-accumulate datapath of a big-number engine whose words are `WORD_W` bits (256 by default). Each issued operation takes two source words and picks one quarter-width slice (`WORD_W/4` bits) from each by a 2-bit index. It multiplies the two slices into a half-width product and moves that product up by zero, one or two quarter widths. It then adds the result into a full-width accumulator held inside the unit. The accumulator may be cleared first, so a new chain of products starts with no separate instruction.

Each operation also carries a result mode. The mode can leave the result in the accumulator only, emit the whole updated accumulator as a destination word, or retire its low half into a chosen half of a destination word. In the last case the accumulator then drops by half a word. By chaining shift-out operations, software builds a full `WORD_W x WORD_W` product in two destination words with no add instructions in between. The destination storage sits outside the unit and is written through two half-word enables.

Top module: `qmac_unit`

## Requirements
- R1: A quarter index k (0..3) picks bits `[k*WORD_W/4 +: WORD_W/4]` of its source word. Index `qsel_a` applies to `src_a` and `qsel_b` applies to `src_b`. The two slices are multiplied without sign into a `WORD_W/2`-bit product.
- R2: The product is shifted left before it is added. `shift_code` 0 gives no shift, 1 gives `WORD_W/4` bits and 2 gives `WORD_W/2` bits. Code 3 is reserved and gives no shift.
- R3: The shifted product is added to the accumulator modulo 2^`WORD_W`. Any carry out of the top bit is dropped.
- R4: When `zero_acc` is 1, the old accumulator is taken as zero, so the updated value is the shifted product alone.
- R5: `out_mode` 1 (whole-word write) presents the updated accumulator on `res_word` with both `res_we_lo` and `res_we_hi` high. The accumulator keeps the updated value.
- R6: `out_mode` 2 (shift-out) presents the low `WORD_W/2` bits of the updated value in both halves of `res_word`. It raises only `res_we_lo` when `half_sel` is 0, and only `res_we_hi` when `half_sel` is 1, so the other destination half is left unchanged.
- R7: After a shift-out, the accumulator holds the updated value shifted right by `WORD_W/2` bits, with zeros in the top half.
- R8: Results and accumulator updates appear on the clock edge after the one where `in_valid` is sampled high. Back-to-back operations are accepted every cycle. On a cycle with no valid operation, `res_valid` and both enables are low and the accumulator holds.
- R9: A synchronous active-high `rst` clears the accumulator, `res_valid` and both write enables.
- R10: `out_mode` 0 (accumulate only) and the reserved code 3 update the accumulator but keep both write enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | WORD_W | First source word |
| src_b | input | WORD_W | Second source word |
| qsel_a | input | 2 | Quarter index into `src_a` |
| qsel_b | input | 2 | Quarter index into `src_b` |
| shift_code | input | 2 | Product shift: 0, 1/4 word, 1/2 word, reserved |
| zero_acc | input | 1 | Clear accumulator before adding |
| out_mode | input | 2 | 0 accumulate, 1 whole write, 2 shift-out, 3 reserved |
| half_sel | input | 1 | Shift-out target half: 0 low, 1 high |
| acc_q | output | WORD_W | Current accumulator |
| res_valid | output | 1 | An operation completed this cycle |
| res_word | output | WORD_W | Destination data |
| res_we_lo | output | 1 | Write enable for destination low half |
| res_we_hi | output | 1 | Write enable for destination high half |

## Verification
A corrupted accumulator is visible on `acc_q` one cycle after the operation that caused it. It also spreads into every later result of the same chain, so a sixteen-product wide multiply compared against a reference product shows any single bad quarter, shift or shift-out step. A wrong half enable shows on the cycle after the shift-out, and it also leaves a stale half in the assembled destination words. A missing shift-down leaves nonzero bits in the top of `acc_q` on the very next cycle.

// File: rtl/qmac_pkg.sv
package qmac_pkg;
  typedef enum logic [1:0] {
    OM_ACC  = 2'd0,
    OM_WORD = 2'd1,
    OM_HALF = 2'd2,
    OM_RSVD = 2'd3
  } out_mode_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_QTR  = 2'd1,
    SH_HALF = 2'd2,
    SH_RSVD = 2'd3
  } shift_e;
endpackage

// File: rtl/qmac_qsel.sv
module qmac_qsel #(
  parameter int WORD_W = 256,
  parameter int NUM_Q  = 4
) (
  input  logic [WORD_W-1:0]         word,
  input  logic [$clog2(NUM_Q)-1:0]  sel,
  output logic [WORD_W/NUM_Q-1:0]   slice
);
  localparam int QW = WORD_W / NUM_Q;

  logic [QW-1:0] parts [NUM_Q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_part
    assign parts[g] = word[g*QW +: QW];
  end

  assign slice = parts[sel];
endmodule

// File: rtl/qmac_mul.sv
module qmac_mul #(
  parameter int QW = 64
) (
  input  logic [QW-1:0]   a,
  input  logic [QW-1:0]   b,
  output logic [2*QW-1:0] prod
);
  logic [2*QW-1:0] a_ext;
  logic [2*QW-1:0] b_ext;

  assign a_ext = {{QW{1'b0}}, a};
  assign b_ext = {{QW{1'b0}}, b};
  assign prod  = a_ext * b_ext;
endmodule

// File: rtl/qmac_align.sv
module qmac_align
  import qmac_pkg::*;
#(
  parameter int WORD_W = 256
) (
  input  logic [WORD_W/2-1:0] prod,
  input  logic [1:0]          code,
  output logic [WORD_W-1:0]   addend
);
  localparam int QW = WORD_W / 4;
  localparam int HW = WORD_W / 2;

  logic [WORD_W-1:0] ext;
  shift_e            sc;

  assign ext = {{HW{1'b0}}, prod};
  assign sc  = shift_e'(code);

  always_comb begin
    case (sc)
      SH_QTR:  addend = ext << QW;
      SH_HALF: addend = ext << HW;
      default: addend = ext;
    endcase
  end
endmodule

// File: rtl/qmac_acc_next.sv
module qmac_acc_next #(
  parameter int WORD_W = 256
) (
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] addend,
  input  logic              clear,
  input  logic              drop_half,
  output logic [WORD_W-1:0] sum,
  output logic [WORD_W-1:0] acc_next
);
  localparam int HW = WORD_W / 2;

  logic [WORD_W-1:0] base;

  assign base     = clear ? '0 : acc;
  assign sum      = base + addend;
  assign acc_next = drop_half ? {{HW{1'b0}}, sum[WORD_W-1:HW]} : sum;
endmodule

// File: rtl/qmac_unit.sv
module qmac_unit
  import qmac_pkg::*;
#(
  parameter int WORD_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic [1:0]        qsel_a,
  input  logic [1:0]        qsel_b,
  input  logic [1:0]        shift_code,
  input  logic              zero_acc,
  input  logic [1:0]        out_mode,
  input  logic              half_sel,
  output logic [WORD_W-1:0] acc_q,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic              res_we_lo,
  output logic              res_we_hi
);
  localparam int NUM_Q = 4;
  localparam int QW    = WORD_W / NUM_Q;
  localparam int HW    = WORD_W / 2;

  logic [QW-1:0]     op_a;
  logic [QW-1:0]     op_b;
  logic [HW-1:0]     prod;
  logic [WORD_W-1:0] addend;
  logic [WORD_W-1:0] sum;
  logic [WORD_W-1:0] acc_next;
  out_mode_e         mode;
  logic              is_half;
  logic              is_word;

  assign mode    = out_mode_e'(out_mode);
  assign is_half = (mode == OM_HALF);
  assign is_word = (mode == OM_WORD);

  qmac_qsel #(.WORD_W(WORD_W), .NUM_Q(NUM_Q)) sel_a_i (
    .word (src_a), .sel (qsel_a), .slice (op_a)
  );

  qmac_qsel #(.WORD_W(WORD_W), .NUM_Q(NUM_Q)) sel_b_i (
    .word (src_b), .sel (qsel_b), .slice (op_b)
  );

  qmac_mul #(.QW(QW)) mul_i (
    .a (op_a), .b (op_b), .prod (prod)
  );

  qmac_align #(.WORD_W(WORD_W)) align_i (
    .prod (prod), .code (shift_code), .addend (addend)
  );

  qmac_acc_next #(.WORD_W(WORD_W)) accn_i (
    .acc       (acc_q),
    .addend    (addend),
    .clear     (zero_acc),
    .drop_half (is_half),
    .sum       (sum),
    .acc_next  (acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      res_valid <= 1'b0;
      res_word  <= '0;
      res_we_lo <= 1'b0;
      res_we_hi <= 1'b0;
    end else begin
      res_valid <= in_valid;
      res_we_lo <= 1'b0;
      res_we_hi <= 1'b0;
      if (in_valid) begin
        acc_q <= acc_next;
        if (is_half) begin
          res_word  <= {sum[HW-1:0], sum[HW-1:0]};
          res_we_lo <= ~half_sel;
          res_we_hi <= half_sel;
        end else begin
          res_word  <= sum;
          res_we_lo <= is_word;
          res_we_hi <= is_word;
        end
      end
    end
  end
endmodule

// File: rtl/qmac_unit_chk.sv
module qmac_unit_chk #(
  parameter int WORD_W = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        out_mode,
  input logic              half_sel,
  input logic [WORD_W-1:0] acc_q,
  input logic              res_valid,
  input logic [WORD_W-1:0] res_word,
  input logic              res_we_lo,
  input logic              res_we_hi
);
  localparam int HW = WORD_W / 2;

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && !res_valid && !res_we_lo && !res_we_hi);

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid && !res_we_lo && !res_we_hi && $stable(acc_q));

  assert_word_write_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_mode == 2'd1) |=> res_we_lo && res_we_hi && (res_word == acc_q));

  assert_half_enable_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_mode == 2'd2) |=>
      ($countones({res_we_hi, res_we_lo}) == 1) && (res_we_hi == $past(half_sel)));

  assert_shift_down_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_mode == 2'd2) |=> (acc_q[WORD_W-1:HW] == '0));

  assert_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (out_mode == 2'd0 || out_mode == 2'd3)) |=> !res_we_lo && !res_we_hi);
endmodule

bind qmac_unit qmac_unit_chk #(.WORD_W(WORD_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_mode  (out_mode),
  .half_sel  (half_sel),
  .acc_q     (acc_q),
  .res_valid (res_valid),
  .res_word  (res_word),
  .res_we_lo (res_we_lo),
  .res_we_hi (res_we_hi)
);

// File: tb/qmac_unit_tb_top.sv
`timescale 1ns/1ps
module qmac_unit_tb_top;
  localparam int W  = 256;
  localparam int QW = W / 4;
  localparam int HW = W / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  src_a = '0;
  logic [W-1:0]  src_b = '0;
  logic [1:0]    qsel_a = '0;
  logic [1:0]    qsel_b = '0;
  logic [1:0]    shift_code = '0;
  logic          zero_acc = 1'b0;
  logic [1:0]    out_mode = '0;
  logic          half_sel = 1'b0;
  logic [W-1:0]  acc_q;
  logic          res_valid;
  logic [W-1:0]  res_word;
  logic          res_we_lo;
  logic          res_we_hi;

  always #2.5 clk = ~clk;

  qmac_unit #(.WORD_W(W)) dut_i (
    .clk, .rst, .in_valid, .src_a, .src_b, .qsel_a, .qsel_b, .shift_code,
    .zero_acc, .out_mode, .half_sel, .acc_q, .res_valid, .res_word,
    .res_we_lo, .res_we_hi
  );

  typedef struct {
    logic [W-1:0] acc;
    logic [W-1:0] word;
    logic         lo;
    logic         hi;
    int           dst;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  logic [W-1:0] model_acc = '0;
  logic [W-1:0] dst_mem [2];
  int           checks = 0;
  int           errors = 0;
  bit           finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                       input int qa, input int qb, input int sh, input bit z,
                       input int mode, input bit hs, input int dst, input string tag);
    logic [QW-1:0] sa;
    logic [QW-1:0] sb;
    logic [HW-1:0] p;
    logic [W-1:0]  sum;
    int            amt;
    exp_t          e;
    @(negedge clk);
    src_a = a; src_b = b; qsel_a = 2'(qa); qsel_b = 2'(qb);
    shift_code = 2'(sh); zero_acc = z; out_mode = 2'(mode); half_sel = hs;
    in_valid = 1'b1;
    sa  = a[qa*QW +: QW];
    sb  = b[qb*QW +: QW];
    p   = HW'(sa) * HW'(sb);
    amt = (sh == 1) ? QW : (sh == 2) ? HW : 0;
    sum = (z ? '0 : model_acc) + (W'(p) << amt);
    model_acc = (mode == 2) ? (sum >> HW) : sum;
    e.acc  = model_acc;
    e.word = (mode == 2) ? {sum[HW-1:0], sum[HW-1:0]} : sum;
    e.lo   = (mode == 1) || (mode == 2 && !hs);
    e.hi   = (mode == 1) || (mode == 2 && hs);
    e.dst  = dst;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (res_valid) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected result", '0, '0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(acc_q == e.acc, e.tag, "acc", acc_q, e.acc);
          chk(res_we_lo == e.lo && res_we_hi == e.hi, e.tag, "enables",
              W'({res_we_hi, res_we_lo}), W'({e.hi, e.lo}));
          if (e.lo) chk(res_word[HW-1:0] == e.word[HW-1:0], e.tag, "low half",
                        W'(res_word[HW-1:0]), W'(e.word[HW-1:0]));
          if (e.hi) chk(res_word[W-1:HW] == e.word[W-1:HW], e.tag, "high half",
                        W'(res_word[W-1:HW]), W'(e.word[W-1:HW]));
          if (e.dst >= 0) begin
            if (res_we_lo) dst_mem[e.dst][HW-1:0] = res_word[HW-1:0];
            if (res_we_hi) dst_mem[e.dst][W-1:HW] = res_word[W-1:HW];
          end
        end
      end else if (res_we_lo || res_we_hi) begin
        chk(1'b0, "R8", "enable without result", W'({res_we_hi, res_we_lo}), '0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] hold;
    logic [2*W-1:0] full;
    logic [W-1:0] half_ref;
    a = {64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210,
         64'h0f1e_2d3c_4b5a_6978, 64'h1111_2222_3333_4444};
    b = {64'hdead_beef_cafe_f00d, 64'h0000_0000_0000_0007,
         64'h8000_0000_0000_0001, 64'h0000_0001_0000_0003};
    dst_mem[0] = {W{1'b1}};
    dst_mem[1] = {W{1'b1}};

    repeat (3) @(negedge clk);
    // R9: reset state
    chk(acc_q == '0, "R9", "acc after reset", acc_q, '0);
    chk(!res_valid && !res_we_lo && !res_we_hi, "R9", "flags after reset",
        W'({res_valid, res_we_hi, res_we_lo}), '0);
    rst = 1'b0;

    // R1 quarter selection, each index, zeroed start
    for (int k = 0; k < 4; k++) issue(a, b, k, 3 - k, 0, 1, 0, 0, -1, "R1");
    // R2 shift codes incl. reserved 3
    for (int s = 0; s < 4; s++) issue(a, b, 1, 2, s, 1, 0, 0, -1, "R2");
    // R3 accumulation and wrap with all-ones quarters at top shift
    issue(a, b, 0, 0, 1, 0, 0, 0, -1, "R3");
    issue({W{1'b1}}, {W{1'b1}}, 3, 3, 2, 1, 0, 0, -1, "R3");
    issue({W{1'b1}}, {W{1'b1}}, 3, 3, 2, 0, 0, 0, -1, "R3");
    issue({W{1'b1}}, {W{1'b1}}, 2, 1, 2, 0, 0, 0, -1, "R3");
    // R4 zeroing discards the wrapped value
    issue(a, b, 2, 3, 1, 1, 0, 0, -1, "R4");
    // R5 whole write, then R10 reserved mode
    issue(a, b, 3, 0, 2, 0, 1, 0, -1, "R5");
    issue(a, b, 0, 2, 1, 0, 3, 1, -1, "R10");
    // R6 and R7 shift-outs to both halves
    issue(a, b, 1, 1, 2, 0, 2, 0, -1, "R6");
    issue(a, b, 3, 1, 2, 0, 2, 1, -1, "R7");
    idle(3);
    // R8: accumulator holds while idle
    hold = acc_q;
    repeat (4) @(negedge clk);
    chk(acc_q == hold && acc_q == model_acc, "R8", "idle hold", acc_q, model_acc);

    // R6 R7: sixteen-product wide multiply into two destination words
    issue(a, b, 0, 0, 0, 1, 0, 0, 0, "R7");
    issue(a, b, 1, 0, 1, 0, 0, 0, 0, "R7");
    issue(a, b, 0, 1, 1, 0, 2, 0, 0, "R6");
    issue(a, b, 2, 0, 0, 0, 0, 0, 0, "R7");
    issue(a, b, 1, 1, 0, 0, 0, 0, 0, "R7");
    issue(a, b, 0, 2, 0, 0, 0, 0, 0, "R7");
    issue(a, b, 3, 0, 1, 0, 0, 0, 0, "R7");
    issue(a, b, 2, 1, 1, 0, 0, 0, 0, "R7");
    issue(a, b, 1, 2, 1, 0, 0, 0, 0, "R7");
    issue(a, b, 0, 3, 1, 0, 2, 1, 0, "R6");
    issue(a, b, 3, 1, 0, 0, 0, 0, 1, "R7");
    issue(a, b, 2, 2, 0, 0, 0, 0, 1, "R7");
    issue(a, b, 1, 3, 0, 0, 0, 0, 1, "R7");
    issue(a, b, 3, 2, 1, 0, 0, 0, 1, "R7");
    issue(a, b, 2, 3, 1, 0, 2, 0, 1, "R6");
    issue(a, b, 3, 3, 0, 0, 2, 1, 1, "R6");
    idle(3);
    full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    chk(dst_mem[0] == full[W-1:0], "R7", "wide product low word", dst_mem[0], full[W-1:0]);
    chk(dst_mem[1] == full[2*W-1:W], "R7", "wide product high word", dst_mem[1], full[2*W-1:W]);

    // R5: half-by-half product from four quarter products
    issue(a, a, 0, 2, 0, 1, 0, 0, -1, "R5");
    issue(a, a, 0, 3, 1, 0, 0, 0, -1, "R5");
    issue(a, a, 1, 2, 1, 0, 0, 0, -1, "R5");
    issue(a, a, 1, 3, 2, 0, 1, 0, -1, "R5");
    idle(2);
    half_ref = W'(a[HW-1:0]) * W'(a[W-1:HW]);
    chk(acc_q == half_ref, "R5", "half-word product", acc_q, half_ref);

    wait (sb_q.size() == 0);
    idle(2);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule